// File: doc/BRIEF.md
# SPI Flash Write-Enable Gate

This block is the command front end of a serial flash device, covering only the write-protection gate. It watches an SPI slave port in SPI mode 0. Bits are taken most significant first on each rising serial clock while chip select is low. The first byte of a frame is the instruction code.

The block keeps a write-enable latch. Two single-byte codes set or clear the latch. Four modifying instructions are accepted only while the latch is set: page program, sector erase, bulk erase and status write. An accepted modifying instruction starts a busy interval of fixed length in system clocks. At the end of that interval a one-cycle completion pulse is raised and the latch clears itself. A status-read instruction returns a byte that shows the busy flag and the latch. The memory array and real program or erase timing are not part of this block. Address and data phases are only counted.

All SPI pins are sampled by the system clock through one register stage, and edges are found by comparing against the previous sample. A chip-select rise is therefore acted on at the second rising system clock edge after it reaches the pin.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset, `wel`, `busy`, `op_done` and `spi_miso_oe` are all 0.
- R2: Code 0x06 (write enable), followed by chip select rising after exactly 8 serial clocks, sets `wel` to 1.
- R3: Code 0x04 (write disable), followed by chip select rising after exactly 8 serial clocks, clears `wel` to 0.
- R4: A 0x06 or 0x04 frame with any bit count other than 8 is aborted and leaves `wel` unchanged.
- R5: A modifying instruction (0x02, 0xD8, 0xC7, 0x01) that arrives while `wel` is 0 is ignored: `busy` stays 0.
- R6: A modifying instruction is accepted only with these exact frame lengths: bulk erase 0xC7 needs 8 bits, status write 0x01 needs 16, sector erase 0xD8 needs 32, and page program 0x02 needs at least 40 bits in whole bytes. Any other length is ignored and leaves `wel` and `busy` unchanged.
- R7: An accepted modifying instruction holds `busy` high for exactly BUSY_CYCLES system clocks. `op_done` pulses for one cycle, in the last busy cycle.
- R8: `wel` is 0 from the cycle after `op_done` onwards.
- R9: The chip-select rise is judged against `busy` as it stands in the cycle after the rise is sampled. If `busy` is 1 then, the instruction is ignored, and this includes a write enable or write disable that lands in the last busy cycle.
- R10: Code 0x05 (status read) is honoured even while busy. From the serial clock fall after the 8th bit, `spi_miso` carries status bytes MSB first, each changing on the falling edge. Each byte is refreshed at its start, with bit 0 = busy, bit 1 = wel and the other bits 0. `spi_miso_oe` is high only in that phase and drops one cycle after chip select rises.
- R11: During every other instruction, including write enable and write disable, `spi_miso_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = high impedance) |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Modifying operation in progress |
| op_done | output | 1 | One-cycle pulse when a modifying operation ends |

## Verification
The tight case is a write-enable frame whose chip-select rise is judged in the very cycle in which the busy interval ends and the latch clears itself. The bench sets off a bulk erase and notes the cycle in which busy is first seen. It shifts a write-enable code in, holds chip select low, and then releases it at a swept offset around the end of the busy interval. For each offset it samples busy in the cycle where the rise is judged. It expects the latch to end at 0 if busy was still high there, and at 1 otherwise.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

    localparam logic [7:0] OPC_SET_WE   = 8'h06;
    localparam logic [7:0] OPC_CLR_WE   = 8'h04;
    localparam logic [7:0] OPC_PROGRAM  = 8'h02;
    localparam logic [7:0] OPC_ERASE_SC = 8'hD8;
    localparam logic [7:0] OPC_ERASE_ALL= 8'hC7;
    localparam logic [7:0] OPC_STAT_WR  = 8'h01;
    localparam logic [7:0] OPC_STAT_RD  = 8'h05;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_WE,
        CMD_CLR_WE,
        CMD_PROGRAM,
        CMD_ERASE_SC,
        CMD_ERASE_ALL,
        CMD_STAT_WR,
        CMD_STAT_RD
    } cmd_e;

    function automatic cmd_e decode_opcode(input logic [7:0] op);
        case (op)
            OPC_SET_WE:    return CMD_SET_WE;
            OPC_CLR_WE:    return CMD_CLR_WE;
            OPC_PROGRAM:   return CMD_PROGRAM;
            OPC_ERASE_SC:  return CMD_ERASE_SC;
            OPC_ERASE_ALL: return CMD_ERASE_ALL;
            OPC_STAT_WR:   return CMD_STAT_WR;
            OPC_STAT_RD:   return CMD_STAT_RD;
            default:       return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             csn,
    input  logic             mosi,
    output logic [7:0]       opcode,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             sclk_fall,
    output logic             cs_rise,
    output logic             cs_high
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

    typedef struct packed {
        logic             sclk_s;
        logic             sclk_p;
        logic             csn_s;
        logic             csn_p;
        logic             mosi_s;
        logic [7:0]       op;
        logic [CNT_W-1:0] cnt;
    } rx_t;

    localparam rx_t RX_RST = '{sclk_s: 1'b0, sclk_p: 1'b0, csn_s: 1'b1, csn_p: 1'b1,
                               mosi_s: 1'b0, op: 8'h00, cnt: '0};

    rx_t  rx_d, rx_q;
    logic sclk_rise;

    always_comb begin
        rx_d        = rx_q;
        rx_d.sclk_s = sclk;
        rx_d.sclk_p = rx_q.sclk_s;
        rx_d.csn_s  = csn;
        rx_d.csn_p  = rx_q.csn_s;
        rx_d.mosi_s = mosi;

        sclk_rise = rx_q.sclk_s & ~rx_q.sclk_p;
        sclk_fall = ~rx_q.sclk_s & rx_q.sclk_p;
        cs_rise   = rx_q.csn_s & ~rx_q.csn_p;
        cs_high   = rx_q.csn_s;

        if (rx_q.csn_s) begin
            // the count stays readable in the rise cycle, cleared afterwards
            rx_d.cnt = '0;
        end else if (sclk_rise) begin
            if (rx_q.cnt < BYTE_BITS) begin
                rx_d.op = {rx_q.op[6:0], rx_q.mosi_s};
            end
            if (rx_q.cnt != CNT_MAX) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end

        opcode  = rx_q.op;
        bit_cnt = rx_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

endmodule

// File: rtl/spi_busy_timer.sv
module spi_busy_timer #(
    parameter int unsigned CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LOAD = W'(CYCLES);
    localparam logic [W-1:0] LAST = W'(1);

    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
    } bt_t;

    bt_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        done = bt_q.busy && (bt_q.cnt == LAST);
        if (bt_q.busy) begin
            if (done) bt_d.busy = 1'b0;
            else      bt_d.cnt  = bt_q.cnt - 1'b1;
        end else if (start) begin
            bt_d.busy = 1'b1;
            bt_d.cnt  = LOAD;
        end
        busy = bt_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bt_q <= '0;
        else        bt_q <= bt_d;
    end

endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_fall,
    input  logic       cs_high,
    input  logic       code_done,
    input  logic       is_stat_rd,
    input  logic [7:0] status,
    output logic       miso,
    output logic       miso_oe
);

    typedef struct packed {
        logic       rd;
        logic [7:0] sh;
        logic [2:0] ocnt;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (cs_high) begin
            tx_d.rd = 1'b0;
        end else if (sclk_fall) begin
            if (!tx_q.rd) begin
                if (code_done && is_stat_rd) begin
                    tx_d.rd   = 1'b1;
                    tx_d.sh   = status;
                    tx_d.ocnt = 3'd0;
                end
            end else if (tx_q.ocnt == 3'd7) begin
                tx_d.sh   = status;
                tx_d.ocnt = 3'd0;
            end else begin
                tx_d.sh   = {tx_q.sh[6:0], 1'b0};
                tx_d.ocnt = tx_q.ocnt + 3'd1;
            end
        end
        miso    = tx_q.sh[7];
        miso_oe = tx_q.rd && !cs_high;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl #(
    parameter int unsigned BUSY_CYCLES = 32,
    parameter int          CNT_W       = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic wel,
    output logic busy,
    output logic op_done
);
    import spi_wel_pkg::*;

    localparam logic [CNT_W-1:0] LEN_1B  = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_2B  = CNT_W'(16);
    localparam logic [CNT_W-1:0] LEN_4B  = CNT_W'(32);
    localparam logic [CNT_W-1:0] LEN_PP  = CNT_W'(40);

    typedef struct packed {
        logic wel;
    } gate_t;

    gate_t            gate_d, gate_q;
    logic [7:0]       opcode;
    logic [CNT_W-1:0] bit_cnt;
    logic             sclk_fall, cs_rise, cs_high;
    logic             start, frame_ok, accept, is_modify;
    cmd_e             cmd;

    spi_rx_frame #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .csn       (spi_csn),
        .mosi      (spi_mosi),
        .opcode    (opcode),
        .bit_cnt   (bit_cnt),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_high   (cs_high)
    );

    spi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (op_done)
    );

    spi_status_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .cs_high    (cs_high),
        .code_done  (bit_cnt == LEN_1B),
        .is_stat_rd (cmd == CMD_STAT_RD),
        .status     ({6'b000000, gate_q.wel, busy}),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

    always_comb begin
        cmd = decode_opcode(opcode);

        case (cmd)
            CMD_SET_WE, CMD_CLR_WE, CMD_ERASE_ALL: frame_ok = (bit_cnt == LEN_1B);
            CMD_STAT_WR:  frame_ok = (bit_cnt == LEN_2B);
            CMD_ERASE_SC: frame_ok = (bit_cnt == LEN_4B);
            CMD_PROGRAM:  frame_ok = (bit_cnt >= LEN_PP) && (bit_cnt[2:0] == 3'd0);
            default:      frame_ok = 1'b0;
        endcase

        is_modify = (cmd == CMD_PROGRAM) || (cmd == CMD_ERASE_SC) ||
                    (cmd == CMD_ERASE_ALL) || (cmd == CMD_STAT_WR);

        accept = cs_rise && !busy && frame_ok;
        start  = accept && is_modify && gate_q.wel;

        gate_d = gate_q;
        if (op_done) begin
            gate_d.wel = 1'b0;
        end else if (accept && cmd == CMD_SET_WE) begin
            gate_d.wel = 1'b1;
        end else if (accept && cmd == CMD_CLR_WE) begin
            gate_d.wel = 1'b0;
        end

        wel = gate_q.wel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

endmodule

// File: rtl/spi_wel_ctrl_chk.sv
module spi_wel_ctrl_chk #(
    parameter int unsigned BUSY_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic spi_miso_oe,
    input logic wel,
    input logic busy,
    input logic op_done
);

    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 32'd1;
        else           busy_len <= '0;
    end

    assert_busy_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel))
        else $error("busy started without latch");

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == BUSY_CYCLES))
        else $error("busy length wrong");

    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> busy)
        else $error("completion outside busy");

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !busy)
        else $error("busy continues after completion");

    assert_done_clears_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !wel)
        else $error("latch survives completion");

    assert_wel_set_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy))
        else $error("latch set while busy");

    assert_oe_framed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !$past(spi_csn))
        else $error("output enabled outside frame");

endmodule

bind spi_wel_ctrl spi_wel_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_miso_oe (spi_miso_oe),
    .wel         (wel),
    .busy        (busy),
    .op_done     (op_done)
);

// File: tb/spi_wel_ctrl_bench.sv
module spi_wel_ctrl_bench;

    localparam int B  = 300;
    localparam int H  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, wel, busy, op_done;

    int n_chk = 0, n_bad = 0, oe_bad = 0, cyc = 0;
    bit in_read = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (miso_oe && !in_read) oe_bad <= oe_bad + 1;

    spi_wel_ctrl #(.BUSY_CYCLES(B)) u_spi_wel_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .wel(wel), .busy(busy), .op_done(op_done));

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end (act timeout, exp completion)");
        finish_run();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit len_ok(input logic [7:0] op, input int n);
        case (op)
            8'h06, 8'h04, 8'hC7: return n == 8;
            8'h01: return n == 16;
            8'hD8: return n == 32;
            8'h02: return (n >= 40) && (n % 8 == 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit is_mod(input logic [7:0] op);
        return op == 8'h02 || op == 8'hD8 || op == 8'hC7 || op == 8'h01;
    endfunction

    task automatic shift_bits(input logic [63:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            mosi = d[n-1-i];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [63:0] d, input int n);
        @(negedge clk);
        csn = 1'b0;
        repeat (H) @(negedge clk);
        shift_bits(d, n);
        repeat (H) @(negedge clk);
        csn = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd8(input logic [7:0] op);
        frame({56'd0, op}, 8);
    endtask

    task automatic read_status(output logic [7:0] st, output int oe_low);
        oe_low = 0;
        @(negedge clk);
        in_read = 1'b1;
        csn = 1'b0;
        repeat (H) @(negedge clk);
        shift_bits(64'h05, 8);
        for (int i = 0; i < 8; i++) begin
            repeat (H) @(negedge clk);
            if (!miso_oe) oe_low++;
            st[7-i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        csn = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 oe drops after frame", int'(miso_oe), 0);
        in_read = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    logic [7:0] st;
    int oel, blen, dn;

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk("R1 wel", int'(wel), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 op_done", int'(op_done), 0);
        chk("R1 oe", int'(miso_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        cmd8(8'h06); chk("R2 set latch", int'(wel), 1);
        cmd8(8'h04); chk("R3 clear latch", int'(wel), 0);
        frame(64'h03, 7);  chk("R4 seven-bit set aborted", int'(wel), 0);
        frame(64'h0C, 9);  chk("R4 nine-bit set aborted", int'(wel), 0);
        cmd8(8'h06);
        frame(64'h02, 7);  chk("R4 seven-bit clear aborted", int'(wel), 1);
        frame(64'h08, 9);  chk("R4 nine-bit clear aborted", int'(wel), 1);
        cmd8(8'h04);

        cmd8(8'hC7);                 chk("R5 erase-all without latch", int'(busy), 0);
        frame(64'hD8_001000, 32);    chk("R5 sector erase without latch", int'(busy), 0);
        frame(64'h02_000000_AA, 40); chk("R5 program without latch", int'(busy), 0);

        cmd8(8'h06);
        frame(64'hC700, 16);         chk("R6 erase-all 16 bits", int'(busy), 0);
        frame(64'hD8_0010, 24);      chk("R6 sector erase 24 bits", int'(busy), 0);
        frame(64'h01, 8);            chk("R6 status write 8 bits", int'(busy), 0);
        frame(64'h02_000000_5, 36);  chk("R6 program 36 bits", int'(busy), 0);
        frame(64'h02_000000_55_3, 44); chk("R6 program 44 bits", int'(busy), 0);
        chk("R6 latch kept", int'(wel), 1);

        read_status(st, oel);
        chk("R10 idle status with latch", int'(st), 8'h02);
        chk("R10 oe during read", oel, 0);

        frame(64'hD8_012000, 32);
        chk("R7 sector erase accepted", int'(busy), 1);
        cmd8(8'h04);
        chk("R9 clear ignored while busy", int'(wel), 1);
        read_status(st, oel);
        chk("R10 status while busy", int'(st), 8'h03);
        blen = 0; dn = 0;
        while (busy) begin
            blen++;
            if (op_done) dn++;
            @(negedge clk);
        end
        chk("R8 latch cleared at end", int'(wel), 0);
        chk("R7 one completion pulse", dn, 1);
        read_status(st, oel);
        chk("R10 status after end", int'(st), 8'h00);

        cmd8(8'h06);
        @(negedge clk); csn = 1'b0; repeat (H) @(negedge clk);
        shift_bits(64'hC7, 8);
        repeat (H) @(negedge clk); csn = 1'b1;
        @(negedge clk); @(negedge clk);
        blen = 0;
        while (busy) begin blen++; @(negedge clk); end
        chk("R7 busy length", blen, B);

        // collision: write-enable close judged on the last busy cycles
        for (int j = 0; j < 6; j++) begin
            int t0;
            logic bseen;
            if (!wel) cmd8(8'h06);
            cmd8(8'hC7);
            while (!busy) @(negedge clk);
            t0 = cyc;
            @(negedge clk); csn = 1'b0; repeat (H) @(negedge clk);
            shift_bits(64'h06, 8);
            while (cyc < t0 + B - 3 + j) @(negedge clk);
            csn = 1'b1;
            @(negedge clk);
            bseen = busy;
            repeat (4) @(negedge clk);
            wait_idle();
            chk($sformatf("R9 collision offset %0d busy_seen %0d", j, bseen),
                int'(wel), bseen ? 0 : 1);
        end

        // random frames, each started from idle
        for (int k = 0; k < 40; k++) begin
            logic [7:0] ops [7] = '{8'h06, 8'h04, 8'h02, 8'hD8, 8'hC7, 8'h01, 8'hAA};
            int lens [8] = '{7, 8, 9, 16, 24, 32, 40, 48};
            logic [7:0] op;
            int n;
            logic [63:0] d;
            bit ok, st_exp, wel_exp;
            op = ops[$urandom_range(0, 6)];
            n  = lens[$urandom_range(0, 7)];
            d  = {$urandom, $urandom};
            d  = d >> (64 - n);
            d[n-1 -: 8] = op;
            ok = len_ok(op, n);
            st_exp  = ok && is_mod(op) && wel;
            wel_exp = wel;
            if (ok && op == 8'h06) wel_exp = 1'b1;
            if (ok && op == 8'h04) wel_exp = 1'b0;
            frame(d, n);
            chk($sformatf("R6 random op %0h len %0d start", op, n), int'(busy), int'(st_exp));
            wait_idle();
            if (st_exp) wel_exp = 1'b0;
            chk($sformatf("R2 R3 R8 random op %0h len %0d latch", op, n), int'(wel), int'(wel_exp));
        end

        chk("R11 oe quiet outside status read", oe_bad, 0);
        finish_run();
    end

endmodule